// File: doc/BRIEF.md
# Thirteen-to-One Wrapping Down Counter

This block presents a descending count on a 4-bit output: 13, 12, and so on down to 1, one step for every clock edge on which the enable is high. After 1 the next step shows 13 again. A one-cycle wrap pulse marks the restart. All logic runs in one clock domain with no derived clocks.

The state register does not count down. It is an up counter modulo 13 that moves through the codes 0 to 12. A purely combinational map turns state k into the shown value 13 - k. Because of this, no illegal-state decode or reset trick is needed to close the loop. If the state register ever holds 13, 14 or 15, the next clock sends it back to 0. A synchronous reset sets the state to 0, so the output reads 13.

Top module: `desc13_counter`

## Requirements
- R1: On each rising clock edge with reset low, enable high and the shown value above 1, the shown value drops by exactly one.
- R2: On a rising clock edge with reset low, enable high and the shown value equal to 1, the shown value becomes 13.
- R3: The shown value is an unsigned 4-bit number with bit 0 as the least significant bit. After reset it is always in the range 1 to 13.
- R4: A rising clock edge with reset high makes the shown value 13 and the wrap output 0, whatever the enable is.
- R5: A rising clock edge with reset low and enable low leaves the shown value unchanged and makes the wrap output 0.
- R6: The wrap output is 1 for exactly the one cycle after a 1-to-13 step. In that cycle the shown value is 13. The wrap output is 0 in every other cycle.
- R7: When reset is high on the edge that would take the value from 1 to 13, reset takes priority and no wrap pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| value | output | 4 | Shown count, 13 down to 1 |
| wrap | output | 1 | One-cycle pulse after the 1-to-13 step |

## Verification
Reset and the wrap step can fall on the same clock edge. The bench provokes this by counting down to 1 and then raising reset and enable together. It then expects a value of 13 with the wrap output low, and expects the wrap output to stay low on the following cycle. A separate case takes a normal wrap and checks that the pulse lasts exactly one cycle and comes with the value 13.

// File: rtl/desc13_pkg.sv
package desc13_pkg;
    localparam int MODULUS = 13;
    localparam int ST_W    = $clog2(MODULUS + 1);

    typedef struct packed {
        logic [ST_W-1:0] st;
        logic            wrap;
    } desc13_regs_t;
endpackage

// File: rtl/desc13_step.sv
module desc13_step #(
    parameter int MOD = 13,
    parameter int W   = 4
) (
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] st_q,
    output logic [W-1:0] st_d,
    output logic         wrap_d
);
    localparam logic [W-1:0] LAST  = W'(MOD - 1);
    localparam logic [W-1:0] LIMIT = W'(MOD);

    always_comb begin
        st_d   = st_q;
        wrap_d = 1'b0;
        if (rst) begin
            st_d = '0;
        end else if (st_q >= LIMIT) begin
            // recovery from a code outside the legal cycle
            st_d = '0;
        end else if (en) begin
            if (st_q == LAST) begin
                st_d   = '0;
                wrap_d = 1'b1;
            end else begin
                st_d = st_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/desc13_map.sv
module desc13_map #(
    parameter int MOD = 13,
    parameter int W   = 4
) (
    input  logic [W-1:0] st,
    output logic [W-1:0] shown
);
    localparam logic [W-1:0] LIMIT = W'(MOD);

    always_comb begin
        if (st < LIMIT) shown = LIMIT - st;
        else            shown = '0;
    end
endmodule

// File: rtl/desc13_counter.sv
module desc13_counter (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [3:0] value,
    output logic       wrap
);
    import desc13_pkg::*;

    desc13_regs_t regs_d, regs_q;
    logic [ST_W-1:0] st_next;
    logic            wrap_next;

    desc13_step #(.MOD(MODULUS), .W(ST_W)) u_step (
        .rst   (rst),
        .en    (en),
        .st_q  (regs_q.st),
        .st_d  (st_next),
        .wrap_d(wrap_next)
    );

    desc13_map #(.MOD(MODULUS), .W(ST_W)) u_map (
        .st   (regs_q.st),
        .shown(value)
    );

    always_comb begin
        regs_d.st   = st_next;
        regs_d.wrap = wrap_next;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign wrap = regs_q.wrap;

    // R3: shown value stays inside 1..13
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        (value >= 4'd1) && (value <= 4'(MODULUS)));

    // R1: one step down per enabled clock
    a_r1_down: assert property (@(posedge clk) disable iff (rst)
        (en && value > 4'd1) |=> (value == $past(value) - 4'd1));

    // R2: 1 wraps to 13
    a_r2_wrap_to_top: assert property (@(posedge clk) disable iff (rst)
        (en && value == 4'd1) |=> (value == 4'(MODULUS)));

    // R5: hold when disabled
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> ($stable(value) && !wrap));

    // R6: wrap pulse only alongside value 13
    a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (value == 4'(MODULUS)));

    // R4, R7: reset wins and suppresses the pulse
    a_r4_reset: assert property (@(posedge clk)
        rst |=> (value == 4'(MODULUS) && !wrap));
endmodule

// File: tb/desc13_counter_bench.sv
`timescale 1ns/1ps
module desc13_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] value;
    logic       wrap;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    desc13_counter u_desc13_counter (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .value(value),
        .wrap (wrap)
    );

    // {rst, en, expected value[3:0], expected wrap}
    localparam int NV = 19;
    localparam logic [6:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd13, 1'b0},
        {1'b0, 1'b1, 4'd12, 1'b0},
        {1'b0, 1'b1, 4'd11, 1'b0},
        {1'b0, 1'b1, 4'd10, 1'b0},
        {1'b0, 1'b1, 4'd9,  1'b0},
        {1'b0, 1'b1, 4'd8,  1'b0},
        {1'b0, 1'b1, 4'd7,  1'b0},
        {1'b0, 1'b1, 4'd6,  1'b0},
        {1'b0, 1'b1, 4'd5,  1'b0},
        {1'b0, 1'b1, 4'd4,  1'b0},
        {1'b0, 1'b1, 4'd3,  1'b0},
        {1'b0, 1'b1, 4'd2,  1'b0},
        {1'b0, 1'b1, 4'd1,  1'b0},
        {1'b0, 1'b1, 4'd13, 1'b1},
        {1'b0, 1'b0, 4'd13, 1'b0},
        {1'b0, 1'b1, 4'd12, 1'b0},
        {1'b0, 1'b0, 4'd12, 1'b0},
        {1'b0, 1'b0, 4'd12, 1'b0},
        {1'b1, 1'b1, 4'd13, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at falling edge, sample 1 ns after the rising edge
    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int wraps;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5]);
            chk($sformatf("R1/R2/R4/R5 vector %0d value", i), value, VEC[i][4:1]);
            chk($sformatf("R6 vector %0d wrap", i), wrap, VEC[i][0]);
        end

        // R4: reset in mid count with enable low
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk("R1 mid count", value, 11);
        step(1'b1, 1'b0);
        chk("R4 reset mid count value", value, 13);
        chk("R4 reset mid count wrap", wrap, 0);

        // R7: reset on the edge that would wrap
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1);
        chk("R7 reached one", value, 1);
        step(1'b1, 1'b1);
        chk("R7 reset beats wrap value", value, 13);
        chk("R7 no wrap pulse", wrap, 0);
        step(1'b0, 1'b0);
        chk("R7 still no wrap pulse", wrap, 0);

        // R3/R6: two full cycles, range and pulse count
        wraps = 0;
        for (int i = 0; i < 26; i++) begin
            step(1'b0, 1'b1);
            chk("R3 in range", int'(value >= 4'd1 && value <= 4'd13), 1);
            if (wrap) begin
                wraps++;
                chk("R6 wrap with 13", value, 13);
            end
        end
        chk("R6 pulse count over two cycles", wraps, 2);
        step(1'b0, 1'b1);
        chk("R6 pulse lasts one cycle", wrap, 0);
        chk("R1 after wrap", value, 12);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule